// File: doc/BRIEF.md
# SPI Master Serial Clock Generator

This block produces the serial clock for an SPI master that can address up to four peripherals. Each peripheral slot has its own divisor, idle polarity and phase setting. The setting for the active slot is applied whenever that slot is selected. A single mode input chooses the base clock. The base clock is either the system clock itself or the system clock slowed by a fixed prescaler of 32. The generator divides the base clock by twice the selected slot's divisor field.

Along with the serial clock, the block drives two single-cycle strobes. A shift register uses the launch strobe to put out the next data bit and the capture strobe to sample the incoming bit. Both strobes are high in the same system cycle in which the serial clock output shows its new level. Shifting data, driving the chip-select pins and inserting delays are left to the neighbouring logic.

Top module: `spi_sclk_gen`

## Requirements
- R1: With `base_div_i` = 0 the base clock advances once per system cycle. With `base_div_i` = 1 it advances once per 32 system cycles.
- R2: Each half period of `sclk_o` lasts N base-clock periods. N is the slot's 8-bit divisor field, held at bits [8*i+7:8*i] of `div_i` for slot i, so the division ratio is 2N (4 to 510).
- R3: Divisor field values 0 and 1 behave as 2.
- R4: The divisor, `cpol_i[i]` and `cpha_i[i]` of slot i take effect only while `cs_idx_i` = i.
- R5: While `en_i` is low, `sclk_o` sits at the selected slot's polarity bit and both strobes stay low.
- R6: The divider restarts on the first cycle after reset, on every cycle with `en_i` low, and on every cycle in which `cs_idx_i` differs from its value in the previous cycle. A restart puts `sclk_o` at the idle level. The first edge then appears in `sclk_o` exactly N×P system cycles after the first enabled cycle without a restart, where P is 1 or 32.
- R7: With the phase bit at 0, `launch_o` marks the leading edge (the first one after idle) and `capture_o` marks the trailing edge.
- R8: With the phase bit at 1, `capture_o` marks the leading edge and `launch_o` marks the trailing edge.
- R9: Each strobe lasts one system cycle and is high exactly in the cycle in which `sclk_o` first shows the new level. The two strobes are never high together.
- R10: While `rst_ni` is low, `sclk_o`, `launch_o` and `capture_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low holds the clock idle |
| base_div_i | input | 1 | Base clock select: 0 system clock, 1 system clock / 32 |
| cs_idx_i | input | 2 | Active slot index |
| div_i | input | 32 | Divisor fields, 8 bits per slot |
| cpol_i | input | 4 | Idle polarity per slot |
| cpha_i | input | 4 | Phase setting per slot |
| sclk_o | output | 1 | Serial clock |
| launch_o | output | 1 | Strobe on the edge that changes data |
| capture_o | output | 1 | Strobe on the edge that samples data |

## Verification
The bench builds the block with its defaults: four slots, 8-bit divisor fields and a prescaler of 32. With these values it can reach the smallest ratio (fields 0 and 1 clamp to 2), the largest ratio of 510, and the slowest setting of 510 × 32 system cycles per serial period. The slots are given different polarity, phase and divisor settings. The run switches slots while the clock is running, holds the clock idle, and returns to the same slot after a disable. A behavioural timing model compares all three outputs on every cycle.

// File: rtl/spi_sclk_pkg.sv
package spi_sclk_pkg;
  typedef enum logic {
    EDGE_LEAD  = 1'b0,
    EDGE_TRAIL = 1'b1
  } edge_pos_t;
endpackage

// File: rtl/spi_sclk_cfg_sel.sv
module spi_sclk_cfg_sel #(
  parameter int NUM_CS = 4,
  parameter int DIV_W  = 8,
  localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic [CS_W-1:0]         idx_i,
  input  logic [NUM_CS*DIV_W-1:0] div_i,
  input  logic [NUM_CS-1:0]       cpol_i,
  input  logic [NUM_CS-1:0]       cpha_i,
  output logic [DIV_W-1:0]        n_eff_o,
  output logic                    cpol_o,
  output logic                    cpha_o
);
  localparam int SLOTS = 2 ** CS_W;

  logic [DIV_W-1:0] div_arr  [SLOTS];
  logic             cpol_arr [SLOTS];
  logic             cpha_arr [SLOTS];

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    if (i < NUM_CS) begin : g_real
      assign div_arr[i]  = div_i[i*DIV_W +: DIV_W];
      assign cpol_arr[i] = cpol_i[i];
      assign cpha_arr[i] = cpha_i[i];
    end else begin : g_pad
      assign div_arr[i]  = '0;
      assign cpol_arr[i] = 1'b0;
      assign cpha_arr[i] = 1'b0;
    end
  end

  logic [DIV_W-1:0] n_raw;
  assign n_raw   = div_arr[idx_i];
  // ratio floor is 4, so half period floor is 2
  assign n_eff_o = (n_raw < DIV_W'(2)) ? DIV_W'(2) : n_raw;
  assign cpol_o  = cpol_arr[idx_i];
  assign cpha_o  = cpha_arr[idx_i];
endmodule

// File: rtl/spi_sclk_prescale.sv
module spi_sclk_prescale #(
  parameter int PRE_DIV = 32,
  localparam int PW     = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic mode_i,
  output logic tick_o
);
  logic [PW-1:0] cnt_q;
  logic          wrap;

  assign wrap   = (cnt_q == PW'(PRE_DIV - 1));
  assign tick_o = mode_i ? wrap : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (wrap)    cnt_q <= '0;
    else              cnt_q <= cnt_q + PW'(1);
  end

  assert_prescale_gap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && tick_o && !clear_i) |=> (!tick_o || !mode_i));
endmodule

// File: rtl/spi_sclk_div.sv
module spi_sclk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             tick_i,
  input  logic [DIV_W-1:0] n_eff_i,
  output logic             toggle_o
);
  logic [DIV_W-1:0] cnt_q;

  assign toggle_o = !clear_i && tick_i && (cnt_q >= n_eff_i - DIV_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (clear_i)  cnt_q <= '0;
    else if (toggle_o) cnt_q <= '0;
    else if (tick_i)   cnt_q <= cnt_q + DIV_W'(1);
  end

  // clamped divisor: first base tick after a restart never ends a half period
  assert_no_early_toggle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0) |-> !toggle_o);
endmodule

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen #(
  parameter int NUM_CS  = 4,
  parameter int DIV_W   = 8,
  parameter int PRE_DIV = 32,
  localparam int CS_W   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic                    base_div_i,
  input  logic [CS_W-1:0]         cs_idx_i,
  input  logic [NUM_CS*DIV_W-1:0] div_i,
  input  logic [NUM_CS-1:0]       cpol_i,
  input  logic [NUM_CS-1:0]       cpha_i,
  output logic                    sclk_o,
  output logic                    launch_o,
  output logic                    capture_o
);
  import spi_sclk_pkg::*;

  logic [DIV_W-1:0] n_eff;
  logic             cpol_sel, cpha_sel;
  logic             tick, toggle, restart;
  logic [CS_W-1:0]  cs_q;
  logic             armed_q;
  edge_pos_t        pos_q;
  logic             sclk_q, launch_q, capture_q;

  spi_sclk_cfg_sel #(.NUM_CS(NUM_CS), .DIV_W(DIV_W)) u_cfg (
    .idx_i  (cs_idx_i),
    .div_i  (div_i),
    .cpol_i (cpol_i),
    .cpha_i (cpha_i),
    .n_eff_o(n_eff),
    .cpol_o (cpol_sel),
    .cpha_o (cpha_sel)
  );

  assign restart = !armed_q || !en_i || (cs_idx_i != cs_q);

  spi_sclk_prescale #(.PRE_DIV(PRE_DIV)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(restart),
    .mode_i (base_div_i),
    .tick_o (tick)
  );

  spi_sclk_div #(.DIV_W(DIV_W)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (restart),
    .tick_i  (tick),
    .n_eff_i (n_eff),
    .toggle_o(toggle)
  );

  logic lead_is_launch;
  assign lead_is_launch = (pos_q == EDGE_LEAD) ^ cpha_sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q      <= '0;
      armed_q   <= 1'b0;
      pos_q     <= EDGE_LEAD;
      sclk_q    <= 1'b0;
      launch_q  <= 1'b0;
      capture_q <= 1'b0;
    end else begin
      cs_q    <= cs_idx_i;
      armed_q <= 1'b1;
      if (restart) begin
        pos_q     <= EDGE_LEAD;
        sclk_q    <= cpol_sel;
        launch_q  <= 1'b0;
        capture_q <= 1'b0;
      end else begin
        launch_q  <= toggle && lead_is_launch;
        capture_q <= toggle && !lead_is_launch;
        if (toggle) begin
          sclk_q <= !sclk_q;
          pos_q  <= (pos_q == EDGE_LEAD) ? EDGE_TRAIL : EDGE_LEAD;
        end
      end
    end
  end

  assign sclk_o    = sclk_q;
  assign launch_o  = launch_q;
  assign capture_o = capture_q;

  assert_idle_level_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (sclk_o == $past(cpol_sel)) && !launch_o && !capture_o);
  assert_strobe_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(launch_o && capture_o));
  assert_strobe_on_edge_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (launch_o || capture_o) |-> (sclk_o != $past(sclk_o)));
  assert_edge_has_strobe_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o != $past(sclk_o)) |-> (launch_o || capture_o || $past(restart)));
  assert_strobe_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_o |=> !launch_o);
endmodule

// File: tb/spi_sclk_gen_tb_top.sv
module spi_sclk_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        base_div = 1'b0;
  logic [1:0]  cs_idx = '0;
  logic [31:0] div = '0;
  logic [3:0]  cpol = '0;
  logic [3:0]  cpha = '0;
  logic        sclk, launch, capture;

  int    n_checks = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  string tag = "R10";

  always #10 clk = ~clk;

  spi_sclk_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .base_div_i(base_div),
    .cs_idx_i(cs_idx), .div_i(div), .cpol_i(cpol), .cpha_i(cpha),
    .sclk_o(sclk), .launch_o(launch), .capture_o(capture)
  );

  // behavioural timing model: edges every N*P enabled cycles after a restart
  bit     m_sclk, m_l, m_c, m_lead, m_armed;
  int     m_t, m_cs;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sclk = 0; m_l = 0; m_c = 0; m_lead = 1; m_armed = 0; m_t = 0; m_cs = 0;
    end else begin
      int c, n, per;
      c = cs_idx;
      n = div[c*8 +: 8];
      if (n < 2) n = 2;
      per = n * (base_div ? 32 : 1);
      m_l = 0; m_c = 0;
      if (!m_armed || !en || c != m_cs) begin
        m_t = 0; m_sclk = cpol[c]; m_lead = 1;
      end else begin
        m_t++;
        if (m_t % per == 0) begin
          m_sclk = !m_sclk;
          if (m_lead != cpha[c]) m_l = 1; else m_c = 1;
          m_lead = !m_lead;
        end
      end
      m_cs = c; m_armed = 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_checks++;
      if (sclk !== m_sclk || launch !== m_l || capture !== m_c) begin
        n_fail++;
        $display("FAIL %s t=%0t sclk/launch/capture actual=%b%b%b expected=%b%b%b",
                 tag, $time, sclk, launch, capture, m_sclk, m_l, m_c);
      end
    end
  end

  task automatic check_bit(string req, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic phase(string t, int c, bit m, bit e, int cycles);
    @(negedge clk);
    tag = t; cs_idx = 2'(c); base_div = m; en = e;
    repeat (cycles) @(negedge clk);
  endtask

  initial begin
    div  = {8'd7, 8'd255, 8'd0, 8'd3};
    cpol = 4'b1010;
    cpha = 4'b0110;
    repeat (3) @(negedge clk);
    check_bit("R10", sclk, 1'b0);
    check_bit("R10", launch, 1'b0);
    check_bit("R10", capture, 1'b0);
    rst_n = 1'b1;
    phase("R7_R2", 0, 0, 1, 60);       // slot0 N=3, phase 0
    phase("R3_R6", 1, 0, 1, 30);       // slot1 field 0 -> 2, phase 1, pol 1
    phase("R8_R4", 2, 0, 1, 1200);     // slot2 N=255, phase 1
    phase("R5", 3, 0, 0, 20);          // idle high (slot3 pol 1)
    phase("R1", 3, 1, 1, 1000);        // slot3 N=7 via /32
    phase("R6", 1, 1, 1, 300);         // switch slot while running
    phase("R5", 1, 0, 0, 5);
    @(negedge clk); div[15:8] = 8'd1;  // field 1 -> 2
    phase("R3", 1, 0, 1, 40);
    phase("R6", 0, 0, 0, 3);
    phase("R9_R7", 0, 0, 1, 50);       // return to same slot after disable
    phase("R1_R2", 2, 1, 1, 33000);    // largest ratio with prescaler
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule